// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. A host drives a mode-select line and a data line, both clocked by a dedicated test clock. A sixteen-state controller walks through separate instruction and data scan branches. The instruction loaded through the instruction branch picks the register placed between the serial input and the serial output: a one-bit bypass stage, a 32-bit identification register, or an external boundary register. For the boundary register the block only provides the select and the strobes. The decoded instruction also drives the mode, clamp and float controls of the pin cells.

The controller has an optional active-low asynchronous reset. Holding the mode-select line high for five clock edges reaches the reset state from any state. The serial output is retimed on the falling edge of the test clock. Its output enable is high only while a shift is in progress, and the pad logic floats the pin at all other times.

Top module: `tap_port`

## Requirements
- R1: On each rising edge of `tck` the controller moves to its next state as chosen by `tms`. `tap_state` reports the state with these codes: 0 reset, 1 idle, 2 select-data, 3 capture-data, 4 shift-data, 5 exit1-data, 6 pause-data, 7 exit2-data, 8 update-data, and 9 to 15 for the same seven steps of the instruction branch, from select-instruction to update-instruction.
- R2: Five consecutive rising edges with `tms` high bring the controller to state 0 from any state. The active instruction then becomes IDCODE.
- R3: When `trst_n` goes low, state 0 and the IDCODE instruction are forced at once, without waiting for a clock edge.
- R4: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is 1 exactly while the state is 4 or 11.
- R5: In capture-instruction the instruction shift stage loads 4'b0101. It shifts least significant bit first, so the first two bits seen on `tdo` are 1 and then 0.
- R6: A shifted instruction takes effect on the falling edge of `tck` in state 15. The pin controls do not change while the instruction is still being shifted or in exit1. On reset the active instruction is IDCODE, code 4'b0010.
- R7: Under IDCODE, a data scan puts out the 32-bit identification value least significant bit first. That bit is always 1.
- R8: Under BYPASS (4'b1111), and under every code not listed in R7, R9, R10 or R11, a data scan goes through one stage that captures 0. `tdo` then repeats `tdi` one clock later.
- R9: EXTEST (4'b0000) and INTEST (4'b0011) set `bsr_select` and `bsr_mode`. SAMPLE/PRELOAD (4'b0001) sets `bsr_select` with `bsr_mode` low. While `bsr_select` is high, `tdo` in data shifts comes from `bsr_tdo`.
- R10: CLAMP (4'b0100) uses the bypass stage and sets `bsr_mode` and `pins_clamp`.
- R11: HIGHZ (4'b0110) uses the bypass stage and sets `pins_highz`, with `bsr_mode` low.
- R12: While `bsr_select` is high, `bsr_capture`, `bsr_shift` and `bsr_update` are high in states 3, 4 and 8 respectively. At all other times they are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, retimed on falling edge |
| tdo_oe | output | 1 | Output enable for the `tdo` pad |
| tap_state | output | 4 | Current controller state code |
| bsr_select | output | 1 | Boundary register is the selected data path |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_shift | output | 1 | Boundary shift strobe |
| bsr_update | output | 1 | Boundary update strobe |
| bsr_mode | output | 1 | Pin cells in test mode |
| pins_clamp | output | 1 | Pins held at boundary-register values |
| pins_highz | output | 1 | All pins forced to high impedance |

## Verification
A behavioural model of the bench predicts the state, the serial output and every pin control after each falling edge, and compares them. The bench targets the corner cases. It runs the five-edge escape from the middle of a data shift, where a design that counts wrongly would stay in a shift state. It drops the reset line asynchronously between edges while in an instruction shift, where a synchronous reset would show a stale state. It checks that HIGHZ stays inactive in exit1, which a design that applies instructions early would get wrong. It also checks the one-clock delay of the bypass stage and the captured zero ahead of it, and that an unused code falls back to bypass.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_DR_SEL   = 4'd2,
        ST_DR_CAP   = 4'd3,
        ST_DR_SHIFT = 4'd4,
        ST_DR_EXIT1 = 4'd5,
        ST_DR_PAUSE = 4'd6,
        ST_DR_EXIT2 = 4'd7,
        ST_DR_UPD   = 4'd8,
        ST_IR_SEL   = 4'd9,
        ST_IR_CAP   = 4'd10,
        ST_IR_SHIFT = 4'd11,
        ST_IR_EXIT1 = 4'd12,
        ST_IR_PAUSE = 4'd13,
        ST_IR_EXIT2 = 4'd14,
        ST_IR_UPD   = 4'd15
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_INTEST  = 4'b0011;
    localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0100;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0110;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0101;

    typedef enum logic [1:0] {
        PATH_BYPASS   = 2'd0,
        PATH_IDCODE   = 2'd1,
        PATH_BOUNDARY = 2'd2
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     test_mode;
        logic     clamp;
        logic     highz;
    } ir_ctrl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   n = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: n = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: n = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: n = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   n = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: n = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: n = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: n = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   n = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic ir_ctrl_t ir_decode(logic [IR_W-1:0] op);
        ir_ctrl_t c;
        c.path      = PATH_BYPASS;
        c.test_mode = 1'b0;
        c.clamp     = 1'b0;
        c.highz     = 1'b0;
        case (op)
            OP_EXTEST, OP_INTEST: begin
                c.path      = PATH_BOUNDARY;
                c.test_mode = 1'b1;
            end
            OP_SAMPLE: c.path = PATH_BOUNDARY;
            OP_IDCODE: c.path = PATH_IDCODE;
            OP_CLAMP: begin
                c.test_mode = 1'b1;
                c.clamp     = 1'b1;
            end
            OP_HIGHZ: c.highz = 1'b1;
            default: ;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= tap_next(state, tms);
    end

    // run length of tms-high edges, saturating, used by the checks below
    logic [2:0] tms_run;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)               tms_run <= '0;
        else if (!tms)             tms_run <= '0;
        else if (tms_run != 3'd5)  tms_run <= tms_run + 3'd1;
    end

    AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run == 3'd5) |-> (state == ST_RESET)); // R2
    AST_IR_SEL_ESCAPE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_SEL && tms) |=> (state == ST_RESET)); // R1
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_active,
    output logic            ir_sout
);
    logic [IR_W-1:0] ir_shift;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                   ir_shift <= IR_CAPTURE_PAT;
        else if (state == ST_IR_CAP)   ir_shift <= IR_CAPTURE_PAT;
        else if (state == ST_IR_SHIFT) ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    // instruction applied on the falling edge, away from the shift edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                 ir_active <= OP_IDCODE;
        else if (state == ST_RESET)  ir_active <= OP_IDCODE;
        else if (state == ST_IR_UPD) ir_active <= ir_shift;
    end

    assign ir_sout = ir_shift[0];

    AST_IR_CAPTURE_LSBS: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_CAP) |=> (ir_shift[1:0] == 2'b01)); // R5
    AST_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_IR_UPD && state != ST_RESET) |-> $stable(ir_active)); // R6
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
)(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_path_e   path,
    output logic       dr_sout
);
    logic            bypass_q;
    logic [ID_W-1:0] id_shift;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            bypass_q <= 1'b0;
            id_shift <= ID_VALUE;
        end else if (state == ST_DR_CAP) begin
            bypass_q <= 1'b0;
            id_shift <= ID_VALUE;
        end else if (state == ST_DR_SHIFT) begin
            if (path == PATH_BYPASS) bypass_q <= tdi;
            if (path == PATH_IDCODE) id_shift <= {tdi, id_shift[ID_W-1:1]};
        end
    end

    assign dr_sout = (path == PATH_IDCODE) ? id_shift[0] : bypass_q;
endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
    import tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_CODE = 32'h4B1D_3A27
)(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    input  logic       tdi,
    input  logic       bsr_tdo,
    output logic       tdo,
    output logic       tdo_oe,
    output logic [3:0] tap_state,
    output logic       bsr_select,
    output logic       bsr_capture,
    output logic       bsr_shift,
    output logic       bsr_update,
    output logic       bsr_mode,
    output logic       pins_clamp,
    output logic       pins_highz
);
    localparam logic [ID_W-1:0] ID_FIXED = {ID_CODE[ID_W-1:1], 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] ir_active;
    logic            ir_sout;
    logic            dr_sout;
    ir_ctrl_t        ctrl;
    logic            serial_bit;
    logic            shifting;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .state     (state),
        .ir_active (ir_active),
        .ir_sout   (ir_sout)
    );

    tap_dr #(.ID_VALUE(ID_FIXED)) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (state),
        .path    (ctrl.path),
        .dr_sout (dr_sout)
    );

    assign ctrl     = ir_decode(ir_active);
    assign shifting = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);

    always_comb begin
        if (state == ST_IR_SHIFT)             serial_bit = ir_sout;
        else if (ctrl.path == PATH_BOUNDARY)  serial_bit = bsr_tdo;
        else                                  serial_bit = dr_sout;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shifting;
            if (shifting) tdo <= serial_bit;
        end
    end

    assign tap_state   = state;
    assign bsr_select  = (ctrl.path == PATH_BOUNDARY);
    assign bsr_capture = bsr_select && (state == ST_DR_CAP);
    assign bsr_shift   = bsr_select && (state == ST_DR_SHIFT);
    assign bsr_update  = bsr_select && (state == ST_DR_UPD);
    assign bsr_mode    = ctrl.test_mode;
    assign pins_clamp  = ctrl.clamp;
    assign pins_highz  = ctrl.highz;

    AST_OE_AFTER_ENTRY: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> ($past(state) inside {ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT2,
                                          ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT2})); // R4
    AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bsr_capture, bsr_shift, bsr_update})); // R12
    AST_HIGHZ_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(pins_highz) |-> (state inside {ST_IR_UPD, ST_RESET})); // R6
endmodule

// File: tb/tap_port_test.sv
`timescale 1ns/1ps
module tap_port_test;
    localparam logic [31:0] IDV = 32'h4B1D_3A27;

    logic tck = 1'b0;
    logic trst_n, tms, tdi, bsr_tdo;
    logic tdo, tdo_oe, bsr_select, bsr_capture, bsr_shift, bsr_update;
    logic bsr_mode, pins_clamp, pins_highz;
    logic [3:0] tap_state;

    always #2.5 tck = ~tck;

    tap_port #(.ID_CODE(IDV)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
        .tdo(tdo), .tdo_oe(tdo_oe), .tap_state(tap_state),
        .bsr_select(bsr_select), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .bsr_mode(bsr_mode), .pins_clamp(pins_clamp),
        .pins_highz(pins_highz)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    int          mst;
    logic [3:0]  m_ir, m_act;
    logic [31:0] m_id;
    logic        m_byp, m_tdo, m_oe;
    logic        q[$];
    int          n_cap, n_shift, n_upd;

    function automatic int nxt(int s, bit t);
        case (s)
            0: return t ? 0 : 1;
            1: return t ? 2 : 1;
            2: return t ? 9 : 3;
            3, 4: return t ? 5 : 4;
            5: return t ? 8 : 6;
            6: return t ? 7 : 6;
            7: return t ? 8 : 4;
            8, 15: return t ? 2 : 1;
            9: return t ? 0 : 10;
            10, 11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            14: return t ? 15 : 11;
            default: return 0;
        endcase
    endfunction

    function automatic int kind(logic [3:0] op); // 0 bypass, 1 id, 2 boundary
        if (op == 4'b0010) return 1;
        if (op == 4'b0000 || op == 4'b0001 || op == 4'b0011) return 2;
        return 0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mst = 0; m_act = 4'b0010; m_oe = 0;
    endtask

    task automatic compare_all();
        int k;
        k = kind(m_act);
        chk("R1", "state", {28'd0, tap_state}, mst);
        chk("R4", "tdo_oe", {31'd0, tdo_oe}, {31'd0, m_oe});
        if (m_oe) chk("R4", "tdo", {31'd0, tdo}, {31'd0, m_tdo});
        chk("R9", "bsr_select", {31'd0, bsr_select}, {31'd0, k == 2});
        chk("R9", "bsr_mode", {31'd0, bsr_mode},
            {31'd0, m_act == 4'b0000 || m_act == 4'b0011 || m_act == 4'b0100});
        chk("R10", "pins_clamp", {31'd0, pins_clamp}, {31'd0, m_act == 4'b0100});
        chk("R11", "pins_highz", {31'd0, pins_highz}, {31'd0, m_act == 4'b0110});
        chk("R12", "strobes", {29'd0, bsr_capture, bsr_shift, bsr_update},
            {29'd0, k == 2 && mst == 3, k == 2 && mst == 4, k == 2 && mst == 8});
    endtask

    task automatic step(bit t, bit d);
        tms = t; tdi = d; bsr_tdo = ~d;
        @(posedge tck);
        if (mst == 10) m_ir = 4'b0101;
        else if (mst == 11) m_ir = {d, m_ir[3:1]};
        if (mst == 3) begin m_id = IDV; m_byp = 1'b0; end
        else if (mst == 4) begin m_id = {d, m_id[31:1]}; m_byp = d; end
        mst = nxt(mst, t);
        @(negedge tck);
        #1;
        if (mst == 0) m_act = 4'b0010;
        else if (mst == 15) m_act = m_ir;
        m_oe = (mst == 4 || mst == 11);
        if (mst == 11) m_tdo = m_ir[0];
        else if (kind(m_act) == 1) m_tdo = m_id[0];
        else if (kind(m_act) == 2) m_tdo = bsr_tdo;
        else m_tdo = m_byp;
        compare_all();
        if (tdo_oe) q.push_back(tdo);
        if (bsr_capture) n_cap++;
        if (bsr_shift) n_shift++;
        if (bsr_update) n_upd++;
    endtask

    task automatic scan_ir(logic [3:0] op);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        q.delete();
        q.push_back(tdo);
        for (int i = 0; i < 4; i++) step(i == 3, op[i]);
        chk("R5", "ir capture bit0", {31'd0, q[0]}, 32'd1);
        chk("R5", "ir capture bit1", {31'd0, q[1]}, 32'd0);
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(int n, logic [31:0] d);
        n_cap = 0; n_shift = 0; n_upd = 0;
        step(1, 0); step(0, 0); step(0, 0);
        q.delete();
        q.push_back(tdo);
        for (int i = 0; i < n; i++) step(i == n - 1, d[i]);
        step(1, 0); step(0, 0);
    endtask

    task automatic check_bypass(string req, int n, logic [31:0] d);
        scan_dr(n, d);
        chk(req, "bypass captured zero", {31'd0, q[0]}, 32'd0);
        for (int i = 1; i < n; i++)
            chk(req, "bypass delay", {31'd0, q[i]}, {31'd0, d[i-1]});
    endtask

    task automatic check_id(string req);
        logic [31:0] got;
        scan_dr(32, 32'hFFFF_0000);
        for (int i = 0; i < 32; i++) got[i] = q[i];
        chk(req, "idcode value", got, IDV);
        chk("R7", "idcode lsb", {31'd0, got[0]}, 32'd1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        trst_n = 0; tms = 1; tdi = 0; bsr_tdo = 0;
        m_ir = 4'b0101; m_id = IDV; m_byp = 0; m_tdo = 0;
        model_reset();
        #12;
        // R3 reset state with clock running
        chk("R3", "reset state", {28'd0, tap_state}, 32'd0);
        chk("R4", "reset oe", {31'd0, tdo_oe}, 32'd0);
        chk("R3", "reset controls", {27'd0, bsr_select, bsr_mode, pins_clamp, pins_highz, bsr_capture}, 32'd0);
        @(negedge tck); #1; trst_n = 1;

        step(0, 0);                    // idle
        check_id("R7");

        scan_ir(4'b1111);              // R8 bypass
        check_bypass("R8", 8, 32'h0000_00B2);

        // pause branch walk inside a bypass scan (R1)
        step(1, 0); step(0, 0); step(0, 1); step(0, 0);
        step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 1); step(0, 1);
        step(1, 0); step(1, 0); step(0, 0);

        scan_ir(4'b1010);              // unused code, R8
        check_bypass("R8", 6, 32'h0000_002D);

        scan_ir(4'b0000);              // EXTEST, R9
        chk("R9", "extest mode", {30'd0, bsr_select, bsr_mode}, 32'd3);
        scan_dr(6, 32'h0000_0019);
        chk("R12", "capture pulses", n_cap, 1);
        chk("R12", "shift pulses", n_shift, 6);
        chk("R12", "update pulses", n_upd, 1);

        scan_ir(4'b0001);              // SAMPLE, R9
        chk("R9", "sample mode", {30'd0, bsr_select, bsr_mode}, 32'd2);
        scan_dr(5, 32'h0000_0015);
        scan_ir(4'b0011);              // INTEST, R9
        chk("R9", "intest mode", {30'd0, bsr_select, bsr_mode}, 32'd3);

        scan_ir(4'b0100);              // CLAMP, R10
        chk("R10", "clamp controls", {29'd0, bsr_select, bsr_mode, pins_clamp}, 32'd3);
        check_bypass("R10", 5, 32'h0000_000D);

        // HIGHZ: no effect before update, R6 then R11
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) step(i == 3, 4'b0110 >> i);
        chk("R6", "highz before update", {31'd0, pins_highz}, 32'd0);
        chk("R6", "clamp before update", {31'd0, pins_clamp}, 32'd1);
        step(1, 0);
        chk("R11", "highz after update", {30'd0, pins_highz, bsr_mode}, 32'd2);
        step(0, 0);
        check_bypass("R11", 4, 32'h0000_0006);

        // five tms-high escape from data shift, R2
        step(1, 0); step(0, 0); step(0, 1);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk("R2", "tms escape state", {28'd0, tap_state}, 32'd0);
        chk("R2", "tms escape highz", {31'd0, pins_highz}, 32'd0);
        step(0, 0);
        check_id("R2");

        // asynchronous reset in the middle of an instruction shift, R3
        scan_ir(4'b1111);
        step(1, 0); step(1, 0); step(0, 0); step(0, 1); step(0, 0);
        trst_n = 0;
        #0.5;
        chk("R3", "async reset state", {28'd0, tap_state}, 32'd0);
        chk("R3", "async reset oe", {31'd0, tdo_oe}, 32'd0);
        model_reset();
        #0.5;
        trst_n = 1;
        step(0, 0);
        check_id("R3");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule